// File: doc/BRIEF.md
# Grouped Glitch-Free Clock Stop Controller

This block sits between a set of already-running source clocks and the pins that carry them. It gates fifteen outputs: four processor clocks, seven bus clocks, one graphics clock, one floppy clock, one keyboard clock and one reference clock. Two controls decide which outputs run. The first is a 2-bit tiered stop code that shuts down nested groups of outputs in a fixed order. The second is a per-output disable mask. An output is stopped whenever either control asks for it. A stopped output sits at logic low. Starting and stopping take place only while the source clock is low, so every high pulse that reaches a pin is a full high phase of its source.

Each output channel carries its stop request and a PLL-running flag into its own clock domain through a two-flop synchronizer. A register clocked on the falling edge then holds the gate enable, so the enable can change only during the low phase. While the PLL flag is deasserted the gate enables are frozen, and no output starts or stops. Output index i maps to mask bit i. Processor clocks use indices 0 to 3, bus clocks 4 to 10, graphics 11, floppy 12, keyboard 13 and reference 14.

Top module: `grp_clk_stop`

## Requirements
- R1: While `rst` is high, every gated output is held low. Once reset is released, every output stays stopped until its synchronized request lets it run.
- R2: Stop code 2'b00 holds the processor, bus, graphics and floppy outputs (indices 0 to 12) low. The keyboard and reference outputs (13, 14) run.
- R3: Stop code 2'b01 lets the bus, graphics and floppy outputs (4 to 12) run and keeps all processor outputs (0 to 3) low.
- R4: Stop code 2'b10 also lets the upper processor outputs (2, 3) run, while processor outputs 0 and 1 stay low.
- R5: Stop code 2'b11 lets every output run.
- R6: The keyboard and reference outputs (13, 14) are never stopped by any stop code. Only their own mask bits stop them.
- R7: Setting mask bit i stops output i whatever the stop code is. The effective stop for each output is the OR of the group stop and its mask bit.
- R8: Every high pulse on a gated output lasts exactly one high phase of its source clock. A stopped output is low.
- R9: A request change first seen at rising edge k of an output's source clock decides the high phase that begins at rising edge k+2. The high phase that begins at edge k+1 still follows the old request.
- R10: While `pll_run` is low, changes to the stop code and the mask do not start or stop any output. After `pll_run` returns high, the pending request takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, sampled in each output's clock domain |
| src_clk | input | PROC_N+BUS_N+4 | Free-running source clock for each output, indexed as the outputs are |
| stop_code | input | 2 | Tiered group stop code |
| dis_mask | input | PROC_N+BUS_N+4 | Individual disable per output; 1 stops that output |
| pll_run | input | 1 | High while the clock sources are valid; low freezes all gating |
| gclk | output | PROC_N+BUS_N+4 | Gated clock outputs |

## Verification
If a channel's enable is wrong, that output shows it at the pins within three periods of its own clock. It appears as a missing pulse, an extra pulse, or a high pulse shorter than the source high phase. A wrong decode of the stop code shows up as the wrong set of running outputs after the settle time, and the first tier to check is the processor lower half. A synchronizer that has one stage too many or too few moves the switching edge by one period, and the exact-edge test on a fast channel detects it. A hold path that fails to freeze when the PLL flag drops lets outputs stop while the flag is low.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

  typedef enum logic [1:0] {
    STOP_WIDE    = 2'b00,
    STOP_PROC    = 2'b01,
    STOP_PROC_LO = 2'b10,
    STOP_NONE    = 2'b11
  } stop_code_e;

  typedef enum logic [1:0] {
    OC_PROC_LO,
    OC_PROC_HI,
    OC_PERIPH,
    OC_ALWAYS
  } out_class_e;

  // Output ordering: processor, bus, graphics, floppy, keyboard, reference.
  function automatic out_class_e classify(input int idx, input int p_n, input int b_n);
    if (idx < p_n / 2)          return OC_PROC_LO;
    if (idx < p_n)              return OC_PROC_HI;
    if (idx < p_n + b_n + 2)    return OC_PERIPH;
    return OC_ALWAYS;
  endfunction

  // Tiers: each higher code releases one more class.
  function automatic logic class_stopped(input out_class_e cls, input stop_code_e code);
    case (cls)
      OC_PROC_LO: return code != STOP_NONE;
      OC_PROC_HI: return (code == STOP_WIDE) || (code == STOP_PROC);
      OC_PERIPH:  return code == STOP_WIDE;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gcs_sync.sv
module gcs_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gcs_decode.sv
module gcs_decode
  import gcs_pkg::*;
#(
  parameter int PROC_N = 4,
  parameter int BUS_N  = 7,
  localparam int OUT_N = PROC_N + BUS_N + 4
) (
  input  logic [1:0]       code,
  output logic [OUT_N-1:0] grp_stop
);
  stop_code_e code_e;
  assign code_e = stop_code_e'(code);

  for (genvar i = 0; i < OUT_N; i++) begin : g_out
    localparam out_class_e CLS = classify(i, PROC_N, BUS_N);
    assign grp_stop[i] = class_stopped(CLS, code_e);
  end
endmodule

// File: rtl/gcs_gate.sv
module gcs_gate #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic rst,
  input  logic stop_req,
  input  logic pll_run,
  output logic gclk
);
  logic stop_s;
  logic pll_s;
  logic en_q;

  gcs_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk(src_clk), .rst(rst), .d(stop_req), .q(stop_s)
  );

  gcs_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_pll_sync (
    .clk(src_clk), .rst(rst), .d(pll_run), .q(pll_s)
  );

  // Enable changes only on the falling edge, i.e. while the source is low.
  always_ff @(negedge src_clk) begin
    if (rst)        en_q <= 1'b0;
    else if (pll_s) en_q <= ~stop_s;
  end

  assign gclk = src_clk & en_q;
endmodule

// File: rtl/grp_clk_stop.sv
module grp_clk_stop #(
  parameter int PROC_N = 4,
  parameter int BUS_N  = 7,
  parameter int STAGES = 2,
  localparam int OUT_N = PROC_N + BUS_N + 4
) (
  input  logic             rst,
  input  logic [OUT_N-1:0] src_clk,
  input  logic [1:0]       stop_code,
  input  logic [OUT_N-1:0] dis_mask,
  input  logic             pll_run,
  output logic [OUT_N-1:0] gclk
);
  logic [OUT_N-1:0] grp_stop;
  logic [OUT_N-1:0] stop_req;

  gcs_decode #(.PROC_N(PROC_N), .BUS_N(BUS_N)) u_dec (
    .code(stop_code), .grp_stop(grp_stop)
  );

  assign stop_req = grp_stop | dis_mask;

  for (genvar i = 0; i < OUT_N; i++) begin : g_ch
    gcs_gate #(.STAGES(STAGES)) u_gate (
      .src_clk (src_clk[i]),
      .rst     (rst),
      .stop_req(stop_req[i]),
      .pll_run (pll_run),
      .gclk    (gclk[i])
    );
  end
endmodule

// File: rtl/grp_clk_stop_chk.sv
module grp_clk_stop_chk #(
  parameter int PROC_N = 4,
  parameter int BUS_N  = 7,
  parameter int STAGES = 2,
  localparam int OUT_N = PROC_N + BUS_N + 4
) (
  input logic             rst,
  input logic [OUT_N-1:0] src_clk,
  input logic [1:0]       stop_code,
  input logic [OUT_N-1:0] dis_mask,
  input logic             pll_run,
  input logic [OUT_N-1:0] gclk
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_chk
    logic [STAGES:0] h_req;
    logic [STAGES:0] h_pll;
    logic [STAGES:0] h_msk;
    logic [3:0]      age;
    logic            req_now;
    logic            vld;

    // Independent restatement of the tier table for index i.
    always_comb begin
      if (i < PROC_N / 2)            req_now = (stop_code != 2'b11);
      else if (i < PROC_N)           req_now = (stop_code[1] == 1'b0);
      else if (i < PROC_N + BUS_N + 2) req_now = (stop_code == 2'b00);
      else                           req_now = 1'b0;
      req_now = req_now | dis_mask[i];
    end

    always_ff @(posedge src_clk[i]) begin
      if (rst) begin
        h_req <= '1;
        h_pll <= '0;
        h_msk <= '1;
        age   <= '0;
      end else begin
        h_req <= {h_req[STAGES-1:0], req_now};
        h_pll <= {h_pll[STAGES-1:0], pll_run};
        h_msk <= {h_msk[STAGES-1:0], dis_mask[i]};
        if (age != 4'hF) age <= age + 4'd1;
      end
    end

    assign vld = (age >= 4'(STAGES + 2));

    // R1: output held low through reset.
    p_reset_low_r1: assert property (@(negedge src_clk[i])
      (rst && $past(rst)) |-> !gclk[i]);

    // R9: the high phase follows the request seen two rising edges earlier.
    p_gate_follow_r9: assert property (@(negedge src_clk[i]) disable iff (rst)
      (vld && h_pll[STAGES]) |-> (gclk[i] == !h_req[STAGES]));

    // R10: gating frozen while the PLL flag is low.
    p_freeze_r10: assert property (@(negedge src_clk[i]) disable iff (rst)
      (vld && !h_pll[STAGES]) |-> (gclk[i] == $past(gclk[i])));

    if (i >= OUT_N - 2) begin : g_always
      // R6: keyboard and reference run unless masked.
      p_always_on_r6: assert property (@(negedge src_clk[i]) disable iff (rst)
        (vld && h_pll[STAGES] && !h_msk[STAGES]) |-> gclk[i]);
    end
  end
endmodule

bind grp_clk_stop grp_clk_stop_chk #(
  .PROC_N(PROC_N), .BUS_N(BUS_N), .STAGES(STAGES)
) u_chk (
  .rst(rst), .src_clk(src_clk), .stop_code(stop_code),
  .dis_mask(dis_mask), .pll_run(pll_run), .gclk(gclk)
);

// File: tb/grp_clk_stop_tb.sv
`timescale 1ns/1ps
module grp_clk_stop_tb;
  localparam int PROC_N = 4;
  localparam int BUS_N  = 7;
  localparam int OUT_N  = PROC_N + BUS_N + 4;

  logic             clk = 1'b0;
  logic             c1  = 1'b0;
  logic             c2  = 1'b0;
  logic             rst = 1'b1;
  logic [OUT_N-1:0] src_clk;
  logic [1:0]       stop_code = 2'b11;
  logic [OUT_N-1:0] dis_mask  = '0;
  logic             pll_run   = 1'b1;
  logic [OUT_N-1:0] gclk;

  int vec_cnt  = 0;
  int fail_cnt = 0;
  int edge_cnt [OUT_N];
  bit done = 0;

  always #5  clk = ~clk;   // 100 MHz
  always #7  c1  = ~c1;
  always #11 c2  = ~c2;

  function automatic int half_of(input int i);
    return (i % 3 == 0) ? 5 : ((i % 3 == 1) ? 7 : 11);
  endfunction

  for (genvar i = 0; i < OUT_N; i++) begin : g_src
    if (i % 3 == 0)      begin : g0 assign src_clk[i] = clk; end
    else if (i % 3 == 1) begin : g1 assign src_clk[i] = c1;  end
    else                 begin : g2 assign src_clk[i] = c2;  end
  end

  grp_clk_stop #(.PROC_N(PROC_N), .BUS_N(BUS_N)) u_dut (
    .rst(rst), .src_clk(src_clk), .stop_code(stop_code),
    .dis_mask(dis_mask), .pll_run(pll_run), .gclk(gclk)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R8 monitor: every high pulse must span a full source high phase.
  for (genvar i = 0; i < OUT_N; i++) begin : g_mon
    time t_rise = 0;
    always @(posedge gclk[i]) begin
      t_rise = $time;
      edge_cnt[i]++;
    end
    always @(negedge gclk[i]) begin
      int w;
      w = int'($time - t_rise);
      check(w == half_of(i), "R8", $sformatf("pulse width out %0d", i), w, half_of(i));
    end
  end

  function automatic bit exp_run(input logic [1:0] code, input logic [OUT_N-1:0] m,
                                 input int i);
    bit stop;
    if (i < 2)           stop = (code != 2'b11);
    else if (i < 4)      stop = (code < 2'b10);
    else if (i < 13)     stop = (code == 2'b00);
    else                 stop = 1'b0;
    return !(stop || m[i]);
  endfunction

  task automatic observe(input logic [1:0] code, input logic [OUT_N-1:0] m,
                         input string req);
    #150;
    for (int i = 0; i < OUT_N; i++) edge_cnt[i] = 0;
    #200;
    for (int i = 0; i < OUT_N; i++) begin
      if (exp_run(code, m, i))
        check(edge_cnt[i] > 0, req, $sformatf("out %0d running", i), edge_cnt[i], 1);
      else
        check(edge_cnt[i] == 0 && gclk[i] == 1'b0, req,
              $sformatf("out %0d parked", i), edge_cnt[i], 0);
    end
  endtask

  task automatic apply(input logic [1:0] code, input logic [OUT_N-1:0] m,
                       input string req);
    stop_code = code;
    dis_mask  = m;
    observe(code, m, req);
  endtask

  task automatic t_reset;
    for (int i = 0; i < OUT_N; i++) edge_cnt[i] = 0;
    #100;
    for (int i = 0; i < OUT_N; i++)
      check(edge_cnt[i] == 0 && gclk[i] == 1'b0, "R1",
            $sformatf("out %0d in reset", i), edge_cnt[i], 0);
    @(posedge clk); #1 rst = 1'b0;
    // Channel 0: still stopped at edge k+1 right after release.
    @(posedge clk); #2;
    check(gclk[0] == 1'b0, "R1", "out 0 just after reset", gclk[0], 0);
  endtask

  task automatic t_codes;
    apply(2'b00, '0, "R2");
    apply(2'b01, '0, "R3");
    apply(2'b10, '0, "R4");
    apply(2'b11, '0, "R5");
    apply(2'b00, '0, "R6");
  endtask

  task automatic t_mask;
    logic [OUT_N-1:0] m;
    m = '0; m[2] = 1'b1; m[13] = 1'b1;
    apply(2'b10, m, "R7");
    m = '0; m[14] = 1'b1; m[5] = 1'b1; m[0] = 1'b1;
    apply(2'b11, m, "R7");
    apply(2'b11, '0, "R7");
  endtask

  task automatic t_latency;
    @(posedge clk); #2 dis_mask[0] = 1'b1;
    @(posedge clk);          // edge k sees the request
    @(posedge clk); #2;      // k+1: old state
    check(gclk[0] == 1'b1, "R9", "stop: phase k+1", gclk[0], 1);
    @(posedge clk); #2;      // k+2: new state
    check(gclk[0] == 1'b0, "R9", "stop: phase k+2", gclk[0], 0);
    #1 dis_mask[0] = 1'b0;
    @(posedge clk);
    @(posedge clk); #2;
    check(gclk[0] == 1'b0, "R9", "start: phase k+1", gclk[0], 0);
    @(posedge clk); #2;
    check(gclk[0] == 1'b1, "R9", "start: phase k+2", gclk[0], 1);
  endtask

  task automatic t_freeze;
    apply(2'b11, '0, "R10");
    pll_run = 1'b0;
    #100;
    stop_code = 2'b00;
    dis_mask  = '1;
    observe(2'b11, '0, "R10");
    dis_mask  = '0;
    pll_run   = 1'b1;
    observe(2'b00, '0, "R10");
  endtask

  task automatic t_random;
    for (int n = 0; n < 60; n++) begin
      stop_code = 2'($urandom_range(0, 3));
      dis_mask  = OUT_N'($urandom) & OUT_N'($urandom);
      #($urandom_range(3, 60));
    end
    observe(stop_code, dis_mask, "R8");
  endtask

  initial begin
    t_reset();
    t_codes();
    t_mask();
    t_latency();
    t_freeze();
    t_random();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fail_cnt++;
      vec_cnt++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
      $finish;
    end
  end
endmodule